// File: doc/BRIEF.md
# Tag Check Fault Dispatcher

This block decides how a memory tag-check failure is reported. When a failure strobe arrives, it takes a two-bit reporting mode from a control word. The field it reads depends on whether the failing access ran at the unprivileged level. Depending on the mode and the access direction, the failure does one of three things:

- it is dropped;
- it becomes a synchronous data abort, carrying a syndrome and the faulting address;
- it sets a sticky flag in an asynchronous fault status register.

One status register is kept per exception level, and software can clear each one through a write port. The flag bit is chosen by address bit 55 when the translation regime has two address ranges. Exception vectoring is done downstream.

Top module: `tcf_dispatch`

## Requirements
- R1: The mode is `ctrl[39:38]` when `fail_unpriv` is 1, and `ctrl[41:40]` otherwise.
- R2: Mode 0: a failure raises no exception and leaves every status bit unchanged.
- R3: Mode 1: every failure raises `exc_vld` in the cycle after the strobe, with `exc_addr` equal to `fail_addr`.
- R4: During an abort, `exc_syn[5:0]` is 0x11 and `exc_syn[6]` equals the write flag of that access.
- R5: Mode 2: every failure sets a status flag and raises no exception.
- R6: Mode 3: a store (`fail_wr`=1) sets a status flag, and a load raises a synchronous abort.
- R7: The flag index is `fail_addr[55]` when `fail_two_rng` is 1, and 0 otherwise. Level L's flag b is `async_stat[2*L+b]`.
- R8: An unprivileged failure records into level 0. Any other failure records into level `fail_lvl`.
- R9: A set flag stays set through later failures until software clears it.
- R10: `clr_vld` clears the bits of level `clr_lvl` that are selected by `clr_mask`. A flag set in the same cycle survives the clear.
- R11: After reset, `exc_vld` is 0 and every status bit is 0. `exc_vld` is high for exactly one cycle per aborting strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fail_vld | input | 1 | Tag-check failure strobe |
| fail_addr | input | 64 | Faulting address |
| fail_wr | input | 1 | 1 for a store, 0 for a load |
| fail_unpriv | input | 1 | Access ran at the unprivileged level |
| fail_two_rng | input | 1 | Translation regime has two address ranges |
| fail_lvl | input | 2 | Regime level for privileged accesses |
| ctrl | input | 64 | System control word holding both mode fields |
| clr_vld | input | 1 | Software clear strobe |
| clr_lvl | input | 2 | Level whose status register is cleared |
| clr_mask | input | 2 | Status bits to clear |
| exc_vld | output | 1 | Synchronous abort strobe |
| exc_syn | output | 7 | Syndrome: {write-not-read, fault status code} |
| exc_addr | output | 64 | Recorded faulting address |
| async_stat | output | 8 | Status registers of all levels, two bits each |

## Verification
The assertions assume the following about the inputs:
- `ctrl` is stable across the cycle in which a strobe is sampled.
- `fail_lvl` and `clr_lvl` always name an existing level.
- Software clears do not coincide with the mode-0 and mode-1 failures whose quiet behaviour is being checked.

The bench drives every strobe for a single cycle at the falling edge. It changes `ctrl` only between strobes and issues clears only in the scenarios dedicated to them, so the stimulus stays inside those assumptions.

// File: rtl/tcf_dispatch.sv
module tcf_dispatch #(
  parameter int ADDR_W  = 64,
  parameter int CTRL_W  = 64,
  parameter int SEL_BIT = 55,
  parameter int NUM_LVL = 4,
  parameter int USR_LO  = 38,
  parameter int PRV_LO  = 40,
  parameter int FSC     = 6'h11,
  localparam int LVL_W  = $clog2(NUM_LVL),
  localparam int STAT_W = 2 * NUM_LVL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_vld,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic              fail_wr,
  input  logic              fail_unpriv,
  input  logic              fail_two_rng,
  input  logic [LVL_W-1:0]  fail_lvl,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              clr_vld,
  input  logic [LVL_W-1:0]  clr_lvl,
  input  logic [1:0]        clr_mask,
  output logic              exc_vld,
  output logic [6:0]        exc_syn,
  output logic [ADDR_W-1:0] exc_addr,
  output logic [STAT_W-1:0] async_stat
);

  logic [1:0]       mode;
  logic             go_sync, go_async;
  logic [LVL_W-1:0] tgt_lvl;
  logic [1:0]       set_bits;
  logic             wnr_q;
  logic             unused_ctrl;

  assign unused_ctrl = ^{ctrl[CTRL_W-1:PRV_LO+2], ctrl[PRV_LO-1:USR_LO+2], ctrl[USR_LO-1:0]};

  assign mode     = fail_unpriv ? ctrl[USR_LO+1:USR_LO] : ctrl[PRV_LO+1:PRV_LO];
  assign go_sync  = fail_vld && ((mode == 2'd1) || (mode == 2'd3 && !fail_wr));
  assign go_async = fail_vld && ((mode == 2'd2) || (mode == 2'd3 &&  fail_wr));
  assign tgt_lvl  = fail_unpriv ? '0 : fail_lvl;
  assign set_bits = !go_async ? 2'b00 :
                    (fail_two_rng && fail_addr[SEL_BIT]) ? 2'b10 : 2'b01;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_vld  <= 1'b0;
      exc_addr <= '0;
      wnr_q    <= 1'b0;
    end else begin
      exc_vld <= go_sync;
      if (go_sync) begin
        exc_addr <= fail_addr;
        wnr_q    <= fail_wr;
      end
    end
  end

  assign exc_syn = {wnr_q, 6'(FSC)};

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [1:0] clr_here, set_here;
    assign clr_here = (clr_vld && clr_lvl == LVL_W'(l)) ? clr_mask : 2'b00;
    assign set_here = (tgt_lvl == LVL_W'(l)) ? set_bits : 2'b00;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) async_stat[2*l +: 2] <= 2'b00;
      else        async_stat[2*l +: 2] <= (async_stat[2*l +: 2] & ~clr_here) | set_here;
    end
  end

  p_sync_report_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_sync |=> exc_vld && exc_addr == $past(fail_addr) && exc_syn[6] == $past(fail_wr));

  p_fsc_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> exc_syn[5:0] == 6'h11);

  p_mode0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_vld && mode == 2'd0 && !clr_vld) |=> !exc_vld && $stable(async_stat));

  p_async_no_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_async |=> !exc_vld && async_stat != '0);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_vld |=> (async_stat & $past(async_stat)) == $past(async_stat));

  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_vld |=> !exc_vld);

  p_one_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_vld && fail_vld) |=> $countones(async_stat ^ $past(async_stat)) <= 1);

endmodule

// File: tb/tb_tcf_dispatch.sv
module tb_tcf_dispatch;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        fail_vld = 0, fail_wr = 0, fail_unpriv = 0, fail_two_rng = 0;
  logic [63:0] fail_addr = '0, ctrl = '0;
  logic [1:0]  fail_lvl = '0, clr_lvl = '0, clr_mask = '0;
  logic        clr_vld = 0;
  logic        exc_vld;
  logic [6:0]  exc_syn;
  logic [63:0] exc_addr;
  logic [7:0]  async_stat;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_stat = '0;

  tcf_dispatch dut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mk_ctrl(input logic [1:0] usr, input logic [1:0] prv);
    mk_ctrl = 64'h0 | (64'(usr) << 38) | (64'(prv) << 40);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strike(input logic [63:0] a, input logic wr, input logic up,
                        input logic two, input logic [1:0] lvl);
    @(negedge clk);
    fail_vld = 1; fail_addr = a; fail_wr = wr; fail_unpriv = up;
    fail_two_rng = two; fail_lvl = lvl;
    @(negedge clk);
    fail_vld = 0;
  endtask

  task automatic soft_clear(input logic [1:0] lvl, input logic [1:0] m);
    @(negedge clk);
    clr_vld = 1; clr_lvl = lvl; clr_mask = m;
    @(negedge clk);
    clr_vld = 0;
    exp_stat[2*lvl +: 2] &= ~m;
  endtask

  task automatic t_reset;
    chk("R11 reset exc_vld", 64'(exc_vld), 64'h0);
    chk("R11 reset status", 64'(async_stat), 64'h0);
  endtask

  task automatic t_mode0;
    ctrl = mk_ctrl(2'd0, 2'd0);
    strike(64'h1234, 1'b0, 1'b0, 1'b0, 2'd1);
    chk("R2 mode0 no exc", 64'(exc_vld), 64'h0);
    chk("R2 mode0 no status", 64'(async_stat), 64'(exp_stat));
  endtask

  task automatic t_mode1;
    ctrl = mk_ctrl(2'd0, 2'd1);
    strike(64'hdead_0000_0000_beef, 1'b1, 1'b0, 1'b0, 2'd1);
    chk("R3 mode1 exc", 64'(exc_vld), 64'h1);
    chk("R3 mode1 addr", exc_addr, 64'hdead_0000_0000_beef);
    chk("R4 fsc", 64'(exc_syn[5:0]), 64'h11);
    chk("R4 wnr store", 64'(exc_syn[6]), 64'h1);
    @(negedge clk);
    chk("R11 one cycle", 64'(exc_vld), 64'h0);
    strike(64'h40, 1'b0, 1'b0, 1'b0, 2'd1);
    chk("R4 wnr load", 64'(exc_syn[6]), 64'h0);
    chk("R2 mode1 no status", 64'(async_stat), 64'(exp_stat));
  endtask

  task automatic t_select;
    ctrl = mk_ctrl(2'd1, 2'd0);
    strike(64'h80, 1'b0, 1'b1, 1'b0, 2'd2);
    chk("R1 unpriv field", 64'(exc_vld), 64'h1);
    strike(64'h80, 1'b0, 1'b0, 1'b0, 2'd2);
    chk("R1 priv field", 64'(exc_vld), 64'h0);
  endtask

  task automatic t_mode2;
    ctrl = mk_ctrl(2'd2, 2'd2);
    strike(64'h0080_0000_0000_0000, 1'b0, 1'b0, 1'b1, 2'd2);
    exp_stat[5] = 1;
    chk("R5 no exc", 64'(exc_vld), 64'h0);
    chk("R7 bit55 high", 64'(async_stat), 64'(exp_stat));
    strike(64'h0080_0000_0000_0000, 1'b1, 1'b0, 1'b0, 2'd3);
    exp_stat[6] = 1;
    chk("R7 one range bit0", 64'(async_stat), 64'(exp_stat));
    strike(64'h10, 1'b0, 1'b1, 1'b1, 2'd3);
    exp_stat[0] = 1;
    chk("R8 unpriv level0", 64'(async_stat), 64'(exp_stat));
    strike(64'h10, 1'b0, 1'b0, 1'b0, 2'd2);
    exp_stat[4] = 1;
    chk("R9 sticky", 64'(async_stat), 64'(exp_stat));
  endtask

  task automatic t_mode3;
    ctrl = mk_ctrl(2'd0, 2'd3);
    strike(64'h0080_0000_0000_0100, 1'b1, 1'b0, 1'b1, 2'd1);
    exp_stat[3] = 1;
    chk("R6 store async", 64'(async_stat), 64'(exp_stat));
    chk("R6 store no exc", 64'(exc_vld), 64'h0);
    strike(64'h200, 1'b0, 1'b0, 1'b1, 2'd1);
    chk("R6 load sync", 64'(exc_vld), 64'h1);
    chk("R6 load addr", exc_addr, 64'h200);
    chk("R6 load status kept", 64'(async_stat), 64'(exp_stat));
  endtask

  task automatic t_clear;
    soft_clear(2'd2, 2'b10);
    chk("R10 partial clear", 64'(async_stat), 64'(exp_stat));
    soft_clear(2'd0, 2'b11);
    chk("R10 level clear", 64'(async_stat), 64'(exp_stat));
    ctrl = mk_ctrl(2'd0, 2'd2);
    @(negedge clk);
    fail_vld = 1; fail_addr = 64'h0; fail_wr = 0; fail_unpriv = 0;
    fail_two_rng = 0; fail_lvl = 2'd3;
    clr_vld = 1; clr_lvl = 2'd3; clr_mask = 2'b11;
    @(negedge clk);
    fail_vld = 0; clr_vld = 0;
    exp_stat[7:6] = 2'b01;
    chk("R10 set beats clear", 64'(async_stat), 64'(exp_stat));
  endtask

  task automatic t_back_to_back;
    ctrl = mk_ctrl(2'd0, 2'd1);
    @(negedge clk);
    fail_vld = 1; fail_addr = 64'hA1; fail_wr = 0; fail_unpriv = 0;
    @(negedge clk);
    chk("R3 b2b first", exc_addr, 64'hA1);
    fail_addr = 64'hB2; fail_wr = 1;
    @(negedge clk);
    fail_vld = 0;
    chk("R3 b2b second", exc_addr, 64'hB2);
    chk("R11 b2b strobe", 64'(exc_vld), 64'h1);
    @(negedge clk);
    chk("R11 b2b end", 64'(exc_vld), 64'h0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_select();
    t_mode2();
    t_mode3();
    t_clear();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule